// File: doc/BRIEF.md
# Memory-Backed Mailbox Message Capture Controller

This block snoops a stream of incoming write transactions and picks out the ones aimed at a programmed mailbox address. Each such write carries a 128-bit message. The block copies the message into a circular queue that lives in external memory at a programmable base address. It advances a hardware write offset after each completed memory write, so software can find new entries.

Software consumes entries from the queue. It tells the block how far it has read by writing back the offset of the last entry it handled. The block compares the next write position against that read offset to detect a full queue. On full it can raise an interrupt, and it can optionally freeze capture until software re-arms it. Every message that lands in memory produces a one-cycle notification pulse on two separately enabled interrupt lines.

All configuration and status go through a small indexed register port with a combinational read path. The memory side is a single write port with a valid/ready handshake.

Top module: `mbox_capture`

## Requirements
- R1: After reset, register 0 (control) reads 0, register 5 (read offset) reads 0x3FFF0, register 6 (write offset) reads 0, mem_valid is low, and all interrupts are low.
- R2: A bus write is a mailbox message only when bus_wr_addr[63:32] equals register 1 and bus_wr_addr[31:4] equals register 2 bits [31:4]. Address bits [3:0] are ignored. Any other write produces no memory write and leaves register 6 unchanged.
- R3: When a message is accepted, mem_valid rises in the next cycle. mem_addr is {register 3, register 4} plus the write offset at acceptance, and mem_data is the payload. Both hold steady until mem_ready is seen.
- R4: In the cycle after a memory handshake, register 6 advances by 16 and wraps to 0 when it reaches the queue size. The queue size is 32 KB shifted left by control bits [9:8].
- R5: Control bit 0 is enable, bit 1 is full-interrupt enable, bit 2 is direct-notify enable, bit 3 is indirect-notify enable, bit 4 is stop-on-full, and bits [9:8] are the size code. Registers 2, 4, 5 and 6 always read with bits [3:0] zero.
- R6: irq_full is high exactly while the write offset plus 16 (wrapped) equals the read offset and control bit 1 is set.
- R7: irq_msg_ind and irq_msg_dir pulse for one cycle, in the cycle after a memory handshake, gated by control bits 3 and 2 respectively.
- R8: If a handshake leaves the queue full while bit 4 is set, later matching messages are dropped. The drop lasts until control is written with bit 0 set while enable was clear.
- R9: A matching message that arrives while enable is clear, while a memory write is pending, or while halted is dropped. It sets sticky control bit 31, which is cleared by writing control with bit 31 set.
- R10: A register write takes effect in the next cycle. A software write to register 6 wins over a hardware advance in the same cycle. Index 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_valid | input | 1 | Snooped write present this cycle |
| bus_wr_addr | input | 64 | Snooped write address |
| bus_wr_data | input | 128 | Snooped write payload |
| cfg_wr | input | 1 | Register write strobe |
| cfg_idx | input | 3 | Register index for read and write |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_idx |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the request |
| mem_addr | output | 64 | Memory byte address of the entry |
| mem_data | output | 128 | Entry contents |
| irq_msg_ind | output | 1 | Indirect new-message pulse |
| irq_msg_dir | output | 1 | Direct new-message pulse |
| irq_full | output | 1 | Queue-full level interrupt |

## Verification
The assertions take for granted that mem_ready is only meaningful while mem_valid is high. They also assume software never writes the size code or the write offset in the same cycle as a handshake, because the offset-step property compares against the previous offset. The stimulus issues register writes only in cycles with no snooped write. It pauses a few cycles after each message before touching register 6, so those overlaps never arise. The ready pattern changes between phases to cover both stalled and immediate handshakes.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam int unsigned REG_W     = 32;
    localparam int unsigned IDX_W     = 3;
    localparam int unsigned SIZE_W    = 2;
    localparam int unsigned MSG_BYTES = 16;
    localparam int unsigned ALIGN     = $clog2(MSG_BYTES);

    // Register indices
    localparam logic [IDX_W-1:0] IDX_CTRL     = 3'd0;
    localparam logic [IDX_W-1:0] IDX_MATCH_HI = 3'd1;
    localparam logic [IDX_W-1:0] IDX_MATCH_LO = 3'd2;
    localparam logic [IDX_W-1:0] IDX_BASE_HI  = 3'd3;
    localparam logic [IDX_W-1:0] IDX_BASE_LO  = 3'd4;
    localparam logic [IDX_W-1:0] IDX_RD_OFF   = 3'd5;
    localparam logic [IDX_W-1:0] IDX_WR_OFF   = 3'd6;

    // Control bit positions
    localparam int unsigned B_EN     = 0;
    localparam int unsigned B_FULLIE = 1;
    localparam int unsigned B_DIRIE  = 2;
    localparam int unsigned B_INDIE  = 3;
    localparam int unsigned B_STOP   = 4;
    localparam int unsigned B_SIZE   = 8;
    localparam int unsigned B_DROP   = 31;

    typedef struct packed {
        logic              drop;
        logic [SIZE_W-1:0] size;
        logic              stop_full;
        logic              ind_ie;
        logic              dir_ie;
        logic              full_ie;
        logic              en;
    } ctrl_t;

    function automatic logic [REG_W-1:0] ctrl_word(input ctrl_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[B_EN]                   = c.en;
        w[B_FULLIE]               = c.full_ie;
        w[B_DIRIE]                = c.dir_ie;
        w[B_INDIE]                = c.ind_ie;
        w[B_STOP]                 = c.stop_full;
        w[B_SIZE+SIZE_W-1:B_SIZE] = c.size;
        w[B_DROP]                 = c.drop;
        return w;
    endfunction
endpackage

// File: rtl/mbox_regs.sv
module mbox_regs
    import mbox_pkg::*;
#(
    parameter int unsigned OFF_W = 18
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [IDX_W-1:0]     cfg_idx,
    input  logic [REG_W-1:0]     cfg_wdata,
    output logic [REG_W-1:0]     cfg_rdata,
    input  logic                 hw_adv,
    input  logic [OFF_W-1:0]     hw_wr_next,
    input  logic                 drop_set,
    input  logic                 halt_set,
    output ctrl_t                ctrl,
    output logic [REG_W-1:0]     match_hi,
    output logic [REG_W-1:0]     match_lo,
    output logic [2*REG_W-1:0]   base,
    output logic [OFF_W-1:0]     rd_off,
    output logic [OFF_W-1:0]     wr_off,
    output logic                 halted
);
    localparam logic [OFF_W-1:0] RD_RST = {{(OFF_W-ALIGN){1'b1}}, {ALIGN{1'b0}}};

    typedef struct packed {
        ctrl_t            ctrl;
        logic [REG_W-1:0] mhi;
        logic [REG_W-1:0] mlo;
        logic [REG_W-1:0] bhi;
        logic [REG_W-1:0] blo;
        logic [OFF_W-1:0] rd;
        logic [OFF_W-1:0] wr;
        logic             halted;
    } regs_t;

    regs_t s_d, s_q;

    function automatic logic [REG_W-1:0] align_word(input logic [REG_W-1:0] w);
        return {w[REG_W-1:ALIGN], {ALIGN{1'b0}}};
    endfunction

    function automatic logic [OFF_W-1:0] align_off(input logic [REG_W-1:0] w);
        return {w[OFF_W-1:ALIGN], {ALIGN{1'b0}}};
    endfunction

    always_comb begin
        s_d = s_q;
        if (hw_adv) begin
            s_d.wr = hw_wr_next;
        end
        if (cfg_wr) begin
            case (cfg_idx)
                IDX_CTRL: begin
                    s_d.ctrl.en        = cfg_wdata[B_EN];
                    s_d.ctrl.full_ie   = cfg_wdata[B_FULLIE];
                    s_d.ctrl.dir_ie    = cfg_wdata[B_DIRIE];
                    s_d.ctrl.ind_ie    = cfg_wdata[B_INDIE];
                    s_d.ctrl.stop_full = cfg_wdata[B_STOP];
                    s_d.ctrl.size      = cfg_wdata[B_SIZE+SIZE_W-1:B_SIZE];
                    if (cfg_wdata[B_DROP]) begin
                        s_d.ctrl.drop = 1'b0;
                    end
                    if (cfg_wdata[B_EN] && !s_q.ctrl.en) begin
                        s_d.halted = 1'b0;
                    end
                end
                IDX_MATCH_HI: s_d.mhi = cfg_wdata;
                IDX_MATCH_LO: s_d.mlo = align_word(cfg_wdata);
                IDX_BASE_HI:  s_d.bhi = cfg_wdata;
                IDX_BASE_LO:  s_d.blo = align_word(cfg_wdata);
                IDX_RD_OFF:   s_d.rd  = align_off(cfg_wdata);
                IDX_WR_OFF:   s_d.wr  = align_off(cfg_wdata);
                default: ;
            endcase
        end
        if (drop_set) begin
            s_d.ctrl.drop = 1'b1;
        end
        if (halt_set) begin
            s_d.halted = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.rd <= RD_RST;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        case (cfg_idx)
            IDX_CTRL:     cfg_rdata = ctrl_word(s_q.ctrl);
            IDX_MATCH_HI: cfg_rdata = s_q.mhi;
            IDX_MATCH_LO: cfg_rdata = s_q.mlo;
            IDX_BASE_HI:  cfg_rdata = s_q.bhi;
            IDX_BASE_LO:  cfg_rdata = s_q.blo;
            IDX_RD_OFF:   cfg_rdata = {{(REG_W-OFF_W){1'b0}}, s_q.rd};
            IDX_WR_OFF:   cfg_rdata = {{(REG_W-OFF_W){1'b0}}, s_q.wr};
            default:      cfg_rdata = '0;
        endcase
    end

    assign ctrl     = s_q.ctrl;
    assign match_hi = s_q.mhi;
    assign match_lo = s_q.mlo;
    assign base     = {s_q.bhi, s_q.blo};
    assign rd_off   = s_q.rd;
    assign wr_off   = s_q.wr;
    assign halted   = s_q.halted;
endmodule

// File: rtl/mbox_match.sv
module mbox_match
    import mbox_pkg::*;
(
    input  logic               wr_valid,
    input  logic [2*REG_W-1:0] wr_addr,
    input  logic [REG_W-1:0]   match_hi,
    input  logic [REG_W-1:0]   match_lo,
    output logic               hit
);
    localparam logic [REG_W-1:0] LOW_MASK = (REG_W)'((1 << ALIGN) - 1);

    logic hi_eq;
    logic lo_eq;

    always_comb begin
        hi_eq = (wr_addr[2*REG_W-1:REG_W] == match_hi);
        lo_eq = ((wr_addr[REG_W-1:0] & ~LOW_MASK) == match_lo);
        hit   = wr_valid && hi_eq && lo_eq;
    end
endmodule

// File: rtl/mbox_ring.sv
module mbox_ring
    import mbox_pkg::*;
#(
    parameter int unsigned MIN_LOG2 = 15,
    parameter int unsigned OFF_W    = 18
) (
    input  logic [SIZE_W-1:0] size_sel,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [OFF_W-1:0]  wr_next,
    output logic              full_now,
    output logic              full_after
);
    localparam int unsigned NSIZE = 1 << SIZE_W;
    localparam logic [OFF_W:0] STEP = (OFF_W+1)'(MSG_BYTES);

    logic [OFF_W:0] lim_tab [NSIZE];
    logic [OFF_W:0] limit;
    logic [OFF_W-1:0] wr_next2;

    for (genvar g = 0; g < NSIZE; g++) begin : g_lim
        assign lim_tab[g] = {{OFF_W{1'b0}}, 1'b1} << (MIN_LOG2 + g);
    end

    function automatic logic [OFF_W-1:0] step(input logic [OFF_W-1:0] o,
                                              input logic [OFF_W:0]   lim);
        logic [OFF_W:0] s;
        s = {1'b0, o} + STEP;
        return (s >= lim) ? '0 : s[OFF_W-1:0];
    endfunction

    always_comb begin
        limit      = lim_tab[size_sel];
        wr_next    = step(wr_off, limit);
        wr_next2   = step(wr_next, limit);
        full_now   = (wr_next == rd_off);
        full_after = (wr_next2 == rd_off);
    end
endmodule

// File: rtl/mbox_capture.sv
module mbox_capture
    import mbox_pkg::*;
#(
    parameter int unsigned MIN_FIFO_LOG2 = 15,
    parameter int unsigned DATA_W        = 128
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr_valid,
    input  logic [2*REG_W-1:0]     bus_wr_addr,
    input  logic [DATA_W-1:0]      bus_wr_data,
    input  logic                   cfg_wr,
    input  logic [IDX_W-1:0]       cfg_idx,
    input  logic [REG_W-1:0]       cfg_wdata,
    output logic [REG_W-1:0]       cfg_rdata,
    output logic                   mem_valid,
    input  logic                   mem_ready,
    output logic [2*REG_W-1:0]     mem_addr,
    output logic [DATA_W-1:0]      mem_data,
    output logic                   irq_msg_ind,
    output logic                   irq_msg_dir,
    output logic                   irq_full
);
    localparam int unsigned ADDR_W = 2 * REG_W;
    localparam int unsigned OFF_W  = MIN_FIFO_LOG2 + (1 << SIZE_W) - 1;

    typedef struct packed {
        logic              pend;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              pulse;
    } cap_t;

    cap_t c_d, c_q;

    ctrl_t             ctrl;
    logic [REG_W-1:0]  match_hi;
    logic [REG_W-1:0]  match_lo;
    logic [ADDR_W-1:0] base;
    logic [OFF_W-1:0]  rd_off;
    logic [OFF_W-1:0]  wr_off;
    logic [OFF_W-1:0]  wr_next;
    logic              halted;
    logic              bus_hit;
    logic              full_now;
    logic              full_after;
    logic              accept;
    logic              handshake;
    logic              drop_set;
    logic              halt_set;

    mbox_regs #(.OFF_W(OFF_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_idx    (cfg_idx),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .hw_adv     (handshake),
        .hw_wr_next (wr_next),
        .drop_set   (drop_set),
        .halt_set   (halt_set),
        .ctrl       (ctrl),
        .match_hi   (match_hi),
        .match_lo   (match_lo),
        .base       (base),
        .rd_off     (rd_off),
        .wr_off     (wr_off),
        .halted     (halted)
    );

    mbox_match u_match (
        .wr_valid (bus_wr_valid),
        .wr_addr  (bus_wr_addr),
        .match_hi (match_hi),
        .match_lo (match_lo),
        .hit      (bus_hit)
    );

    mbox_ring #(.MIN_LOG2(MIN_FIFO_LOG2), .OFF_W(OFF_W)) u_ring (
        .size_sel   (ctrl.size),
        .wr_off     (wr_off),
        .rd_off     (rd_off),
        .wr_next    (wr_next),
        .full_now   (full_now),
        .full_after (full_after)
    );

    always_comb begin
        handshake = c_q.pend && mem_ready;
        accept    = bus_hit && ctrl.en && !c_q.pend && !halted;
        drop_set  = bus_hit && !accept;
        halt_set  = handshake && ctrl.stop_full && full_after;

        c_d       = c_q;
        c_d.pulse = handshake;
        if (handshake) begin
            c_d.pend = 1'b0;
        end
        if (accept) begin
            c_d.pend = 1'b1;
            c_d.addr = base + {{(ADDR_W-OFF_W){1'b0}}, wr_off};
            c_d.data = bus_wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign mem_valid   = c_q.pend;
    assign mem_addr    = c_q.addr;
    assign mem_data    = c_q.data;
    assign irq_msg_ind = c_q.pulse && ctrl.ind_ie;
    assign irq_msg_dir = c_q.pulse && ctrl.dir_ie;
    assign irq_full    = full_now && ctrl.full_ie;
endmodule

// File: rtl/mbox_capture_chk.sv
module mbox_capture_chk
    import mbox_pkg::*;
#(
    parameter int unsigned OFF_W  = 18,
    parameter int unsigned DATA_W = 128
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_wr,
    input logic [IDX_W-1:0]   cfg_idx,
    input logic [REG_W-1:0]   cfg_wdata,
    input logic               bus_hit,
    input logic               mem_valid,
    input logic               mem_ready,
    input logic [2*REG_W-1:0] mem_addr,
    input logic [DATA_W-1:0]  mem_data,
    input logic               irq_msg_ind,
    input logic               irq_full,
    input logic [OFF_W-1:0]   wr_off,
    input logic               halted,
    input logic               drop_flag,
    input logic               full_ie
);
    // R2
    no_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_hit && !mem_valid) |=> !mem_valid);

    // R3
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

    // R4
    off_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && !cfg_wr) |=> (wr_off != $past(wr_off)));

    // R4
    off_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_off[ALIGN-1:0] == '0);

    // R6
    full_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !full_ie |-> !irq_full);

    // R7
    pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_msg_ind |-> $past(mem_valid && mem_ready));

    // R8
    halt_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> !$rose(mem_valid));

    // R9
    drop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_flag && !(cfg_wr && cfg_idx == IDX_CTRL && cfg_wdata[B_DROP])) |=> drop_flag);
endmodule

bind mbox_capture mbox_capture_chk #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr      (cfg_wr),
    .cfg_idx     (cfg_idx),
    .cfg_wdata   (cfg_wdata),
    .bus_hit     (bus_hit),
    .mem_valid   (mem_valid),
    .mem_ready   (mem_ready),
    .mem_addr    (mem_addr),
    .mem_data    (mem_data),
    .irq_msg_ind (irq_msg_ind),
    .irq_full    (irq_full),
    .wr_off      (wr_off),
    .halted      (halted),
    .drop_flag   (ctrl.drop),
    .full_ie     (ctrl.full_ie)
);

// File: tb/mbox_capture_tb.sv
`timescale 1ns/1ps
module mbox_capture_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr_valid = 1'b0;
    logic [63:0]  bus_wr_addr = '0;
    logic [127:0] bus_wr_data = '0;
    logic         cfg_wr = 1'b0;
    logic [2:0]   cfg_idx = '0;
    logic [31:0]  cfg_wdata = '0;
    logic [31:0]  cfg_rdata;
    logic         mem_valid;
    logic         mem_ready = 1'b0;
    logic [63:0]  mem_addr;
    logic [127:0] mem_data;
    logic         irq_msg_ind;
    logic         irq_msg_dir;
    logic         irq_full;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [7:0] rdy_pat = 8'hFF;
    logic [2:0] idx_rot = '0;
    logic       live = 1'b0;

    always #2.5 clk = ~clk;

    mbox_capture u_dut (
        .clk(clk), .rst_n(rst_n),
        .bus_wr_valid(bus_wr_valid), .bus_wr_addr(bus_wr_addr), .bus_wr_data(bus_wr_data),
        .cfg_wr(cfg_wr), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
        .irq_msg_ind(irq_msg_ind), .irq_msg_dir(irq_msg_dir), .irq_full(irq_full)
    );

    // ---------------- reference model ----------------
    logic [31:0]  m_ctrl, m_hi, m_lo, m_bhi, m_blo;
    int           m_rd, m_wr;
    logic         m_pend, m_pulse, m_halt, m_drop;
    logic [63:0]  m_addr;
    logic [127:0] m_data;

    function automatic int m_size();
        return 32768 << m_ctrl[9:8];
    endfunction

    function automatic int m_adv(input int o);
        return (o + 16 >= m_size()) ? 0 : o + 16;
    endfunction

    function automatic logic [31:0] m_read(input logic [2:0] i);
        case (i)
            3'd0: return {m_drop, m_ctrl[30:0]};
            3'd1: return m_hi;
            3'd2: return m_lo;
            3'd3: return m_bhi;
            3'd4: return m_blo;
            3'd5: return 32'(m_rd);
            3'd6: return 32'(m_wr);
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 0; m_hi = 0; m_lo = 0; m_bhi = 0; m_blo = 0;
            m_rd = 32'h3FFF0; m_wr = 0;
            m_pend = 0; m_pulse = 0; m_halt = 0; m_drop = 0;
            m_addr = 0; m_data = 0;
        end else begin
            logic hit, hs, take, hset, dset;
            int   nw;
            hit  = bus_wr_valid && bus_wr_addr[63:32] == m_hi && bus_wr_addr[31:4] == m_lo[31:4];
            hs   = m_pend && mem_ready;
            take = hit && m_ctrl[0] && !m_pend && !m_halt;
            dset = hit && !take;
            nw   = hs ? m_adv(m_wr) : m_wr;
            hset = hs && m_ctrl[4] && (m_adv(nw) == m_rd);
            if (take) begin
                m_addr = {m_bhi, m_blo} + 64'(m_wr);
                m_data = bus_wr_data;
            end
            m_pend  = take ? 1'b1 : (hs ? 1'b0 : m_pend);
            m_pulse = hs;
            m_wr    = nw;
            if (cfg_wr) begin
                case (cfg_idx)
                    3'd0: begin
                        if (cfg_wdata[31]) m_drop = 0;
                        if (cfg_wdata[0] && !m_ctrl[0]) m_halt = 0;
                        m_ctrl = cfg_wdata & 32'h0000_031F;
                    end
                    3'd1: m_hi  = cfg_wdata;
                    3'd2: m_lo  = cfg_wdata & 32'hFFFF_FFF0;
                    3'd3: m_bhi = cfg_wdata;
                    3'd4: m_blo = cfg_wdata & 32'hFFFF_FFF0;
                    3'd5: m_rd  = int'(cfg_wdata & 32'h0003_FFF0);
                    3'd6: m_wr  = int'(cfg_wdata & 32'h0003_FFF0);
                    default: ;
                endcase
            end
            if (dset) m_drop = 1;
            if (hset) m_halt = 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (live && rst_n) begin
            chk(mem_valid == m_pend, "R3", "mem_valid", 128'(mem_valid), 128'(m_pend));
            if (m_pend) begin
                chk(mem_addr == m_addr, "R3", "mem_addr", 128'(mem_addr), 128'(m_addr));
                chk(mem_data == m_data, "R3", "mem_data", mem_data, m_data);
            end
            chk(irq_msg_ind == (m_pulse && m_ctrl[3]), "R7", "irq_msg_ind",
                128'(irq_msg_ind), 128'(m_pulse && m_ctrl[3]));
            chk(irq_msg_dir == (m_pulse && m_ctrl[2]), "R7", "irq_msg_dir",
                128'(irq_msg_dir), 128'(m_pulse && m_ctrl[2]));
            chk(irq_full == (m_ctrl[1] && m_adv(m_wr) == m_rd), "R6", "irq_full",
                128'(irq_full), 128'(m_ctrl[1] && m_adv(m_wr) == m_rd));
            case (cfg_idx)
                3'd0: begin
                    chk(cfg_rdata[30:0] == m_read(0)[30:0], "R5", "ctrl", 128'(cfg_rdata), 128'(m_read(0)));
                    chk(cfg_rdata[31] == m_drop, "R9", "drop bit", 128'(cfg_rdata[31]), 128'(m_drop));
                end
                3'd1, 3'd2: chk(cfg_rdata == m_read(cfg_idx), "R2", "match reg", 128'(cfg_rdata), 128'(m_read(cfg_idx)));
                3'd3, 3'd4: chk(cfg_rdata == m_read(cfg_idx), "R3", "base reg", 128'(cfg_rdata), 128'(m_read(cfg_idx)));
                3'd6: chk(cfg_rdata == m_read(cfg_idx), "R4", "wr offset", 128'(cfg_rdata), 128'(m_read(cfg_idx)));
                default: chk(cfg_rdata == m_read(cfg_idx), "R10", "reg read", 128'(cfg_rdata), 128'(m_read(cfg_idx)));
            endcase
        end
    end

    always @(negedge clk) mem_ready = rdy_pat[cyc % 8];

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- drivers ----------------
    localparam logic [31:0] HI = 32'h1234_5678;
    localparam logic [31:0] LO = 32'h9ABC_DEF0;

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            cfg_wr = 0; bus_wr_valid = 0;
            cfg_idx = idx_rot; idx_rot++;
        end
    endtask

    task automatic cfg(input logic [2:0] i, input logic [31:0] d);
        @(negedge clk);
        bus_wr_valid = 0; cfg_wr = 1; cfg_idx = i; cfg_wdata = d;
    endtask

    task automatic send(input logic [63:0] a, input logic [127:0] d);
        @(negedge clk);
        cfg_wr = 0; bus_wr_valid = 1; bus_wr_addr = a; bus_wr_data = d;
    endtask

    task automatic rd_check(input logic [2:0] i, input logic [31:0] exp, input string tag);
        @(negedge clk);
        cfg_wr = 0; bus_wr_valid = 0; cfg_idx = i;
        #1;
        chk(cfg_rdata == exp, tag, "register read", 128'(cfg_rdata), 128'(exp));
    endtask

    task automatic msg(input logic [3:0] nib, input logic [127:0] d);
        send({HI, LO[31:4], nib}, d);
        idle(3);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        live = 1;
        // R1 reset state
        rd_check(3'd0, 32'h0, "R1");
        rd_check(3'd5, 32'h0003_FFF0, "R1");
        rd_check(3'd6, 32'h0, "R1");
        chk(mem_valid == 0 && irq_full == 0 && irq_msg_ind == 0, "R1", "outputs idle",
            128'({mem_valid, irq_full, irq_msg_ind}), 128'(0));

        // configuration, R5/R10 alignment and index 7
        cfg(3'd1, HI);
        cfg(3'd2, LO | 32'h7);
        cfg(3'd3, 32'h0000_00AB);
        cfg(3'd4, 32'h0010_0008);
        cfg(3'd5, 32'h0000_0100);
        cfg(3'd0, 32'h0000_000F);
        rd_check(3'd2, LO, "R5");
        rd_check(3'd4, 32'h0010_0000, "R5");
        rd_check(3'd7, 32'h0, "R10");
        rd_check(3'd0, 32'h0000_000F, "R5");

        // R2 / R3 / R4 basic capture, low nibble ignored
        msg(4'h3, 128'hDEAD_BEEF_0000_1111_2222_3333_4444_5555);
        rd_check(3'd6, 32'h10, "R4");
        send({HI + 32'h1, LO}, 128'h1);
        idle(3);
        send({HI, LO ^ 32'h10}, 128'h2);
        idle(3);
        rd_check(3'd6, 32'h10, "R2");

        // R9 drop while pending
        rdy_pat = 8'h00;
        send({HI, LO}, 128'hA);
        send({HI, LO}, 128'hB);
        idle(2);
        rd_check(3'd0, 32'h8000_000F, "R9");
        rdy_pat = 8'hFF;
        idle(3);
        rd_check(3'd6, 32'h20, "R3");
        cfg(3'd0, 32'h8000_000F);
        rd_check(3'd0, 32'h0000_000F, "R9");

        // R9 drop while disabled
        cfg(3'd0, 32'h0000_000E);
        msg(4'h0, 128'hC);
        rd_check(3'd0, 32'h8000_000E, "R9");
        rd_check(3'd6, 32'h20, "R9");
        cfg(3'd0, 32'h8000_000F);

        // R4 wrap at 32K, then 64K
        cfg(3'd6, 32'h7FE0);
        msg(4'h1, 128'h11);
        msg(4'h2, 128'h12);
        rd_check(3'd6, 32'h0, "R4");
        msg(4'h3, 128'h13);
        rd_check(3'd6, 32'h10, "R4");
        cfg(3'd0, 32'h0000_010F);
        cfg(3'd6, 32'h7FF0);
        msg(4'h4, 128'h14);
        rd_check(3'd6, 32'h8000, "R4");
        cfg(3'd6, 32'hFFF0);
        msg(4'h5, 128'h15);
        rd_check(3'd6, 32'h0, "R4");

        // R6 full interrupt without stop
        cfg(3'd0, 32'h0000_000F);
        cfg(3'd5, 32'h30);
        cfg(3'd6, 32'h0);
        msg(4'h0, 128'h21);
        msg(4'h0, 128'h22);
        idle(1);
        #1 chk(irq_full == 1, "R6", "full raised", 128'(irq_full), 128'(1));
        cfg(3'd0, 32'h0000_000D);
        idle(1);
        #1 chk(irq_full == 0, "R6", "full masked", 128'(irq_full), 128'(0));
        cfg(3'd0, 32'h0000_000F);
        msg(4'h0, 128'h23);
        rd_check(3'd6, 32'h30, "R6");

        // R8 stop on full
        cfg(3'd0, 32'h0000_001F);
        cfg(3'd6, 32'h30);
        cfg(3'd5, 32'h50);
        msg(4'h0, 128'h31);
        send({HI, LO}, 128'h32);
        idle(1);
        #1 chk(mem_valid == 0, "R8", "halted drop", 128'(mem_valid), 128'(0));
        idle(2);
        rd_check(3'd6, 32'h40, "R8");
        rd_check(3'd0, 32'h8000_001F, "R8");
        cfg(3'd0, 32'h0000_001E);
        cfg(3'd0, 32'h8000_001F);
        cfg(3'd5, 32'h70);
        msg(4'h0, 128'h33);
        rd_check(3'd6, 32'h50, "R8");

        // R10 software offset write beats nothing pending; R7 with notify off and ragged ready
        cfg(3'd0, 32'h0000_0003);
        rdy_pat = 8'b1010_0110;
        for (int k = 0; k < 6; k++) begin
            send({HI, LO[31:4], 4'(k)}, 128'(k * 32'h0101_0101));
            idle(6);
        end
        cfg(3'd0, 32'h0000_000D);
        for (int k = 0; k < 4; k++) begin
            send({HI, LO}, 128'(k + 100));
            idle(5);
        end
        idle(4);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule